// File: doc/BRIEF.md
# Three-Level Trigger Sequence Emulator

This block stands in for a central trigger source while front-end readout electronics is being tested. Each accepted start request marks an interaction and sets off one timed sequence of three trigger levels. The first level goes out either as a pulse on a fast dedicated line or as a strobe on a serial strobe channel. The second level is a strobe on that channel, and a data message tagged with the sequence number follows one cycle later. The third level is a message on the message channel, timed so that it covers the longest protection window.

The latencies are counted in reference-clock cycles, which are 25 ns apart at 40 MHz. The block samples all three latencies when it accepts a sequence. The timing is the same whether or not an error is injected. A sequence can be marked for a deliberate fault, either on demand through a single-cycle request or at random through a free-running 16-bit LFSR compared against a threshold. This lets a downstream consistency checker be exercised. The fault can be a missing strobe, a missing final message, a corrupted data bit, or a final message sent one cycle early.

Top module: `trig_seq_emu`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `l0_o`, `chan_a_o`, `msg_valid_o` and `busy_o` are all low.
- R2: A high `start_i` at a rising edge A while `busy_o` is low is accepted. The latencies D0, D1 and D2 are sampled at A. `busy_o` is high after edges A to A+D2-1 and low after edge A+D2. The latencies must satisfy 1 <= D0 < D1 and D1+4 <= D2.
- R3: When `l0_on_a_i` is low at A, `l0_o` is high for exactly the one cycle after edge A+D0. When it is high, `l0_o` stays low and `chan_a_o` pulses in that cycle instead.
- R4: `chan_a_o` is high for exactly the one cycle after edge A+D1, which is the second-level strobe.
- R5: In the cycle after edge A+D1+1, `msg_valid_o` is high with `msg_lvl_o`=0 and `msg_data_o` equal to the sequence number. The sequence number is the count of sequences accepted since reset, modulo 2^DATA_W, with the first being 0.
- R6: In the cycle after edge A+D2, `msg_valid_o` is high with `msg_lvl_o`=1 and `msg_data_o` equal to the same sequence number.
- R7: A `start_i` seen while `busy_o` is high is ignored. It adds no output and does not advance the sequence number.
- R8: An `err_now_i` pulse marks the next accepted sequence for injection, including one accepted at the same edge. Exactly one sequence is marked.
- R9: With `err_rand_en_i` high, a sequence is marked when the LFSR value at A is less than or equal to `err_thresh_i`. The LFSR uses x^16+x^14+x^13+x^11+1 from a nonzero seed and never holds 0. So a threshold of 0 never marks a sequence and 16'hFFFF always does.
- R10: A marked sequence applies `err_kind_i`, sampled at A:
  - 0 drops the `chan_a_o` strobe at A+D1, while the message at A+D1+1 is still sent.
  - 1 drops the third-level message, while `busy_o` still ends at A+D2.
  - 2 inverts bit 0 of the second-level message data.
  - 3 sends the third-level message after edge A+D2-1 instead of A+D2.
- R11: A latency input of 0 selects the parameter default: 48 for D0, 260 for D1 and 3520 for D2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Interaction / sequence start request |
| l0_on_a_i | input | 1 | Send first level on the strobe channel instead of the fast line |
| l0_dly_i | input | CNT_W | First-level latency in cycles (0 = default) |
| l1_dly_i | input | CNT_W | Second-level latency in cycles (0 = default) |
| l2_dly_i | input | CNT_W | Third-level latency in cycles (0 = default) |
| err_rand_en_i | input | 1 | Enable random error marking |
| err_thresh_i | input | 16 | Random marking threshold |
| err_now_i | input | 1 | One-cycle on-demand error request |
| err_kind_i | input | 2 | Error type select |
| l0_o | output | 1 | Fast first-level line |
| chan_a_o | output | 1 | Strobe channel |
| msg_valid_o | output | 1 | Message channel valid |
| msg_lvl_o | output | 1 | Message level: 0 second, 1 third |
| msg_data_o | output | DATA_W | Message payload (sequence number) |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench aims at the end of a sequence. It holds the start request high so that the next sequence has to be accepted on the first edge after `busy_o` drops. An off-by-one busy window would start that sequence a cycle early or late, and every later pulse would be misplaced. It issues a start request in the middle of a sequence: a design that does not gate starts would emit a second set of pulses or skip a sequence number. It runs each of the four error kinds, then a clean sequence straight after, and issues an on-demand request both together with a start and ahead of one. A sticky or dropped pending flag shows up as a wrong strobe or message on the following sequence. The random thresholds 0 and 16'hFFFF are also run, along with the zero-selects-default latencies.

// File: rtl/trig_emu_pkg.sv
package trig_emu_pkg;
    typedef enum logic [1:0] {
        ERR_DROP_STB = 2'd0,
        ERR_DROP_FIN = 2'd1,
        ERR_FLIP_BIT = 2'd2,
        ERR_EARLY    = 2'd3
    } err_kind_e;

    // one-cycle-ahead timing hits from the sequence counter
    typedef struct packed {
        logic first;
        logic stb;
        logic mid_msg;
        logic fin;
        logic fin_early;
    } hit_t;
endpackage

// File: rtl/trig_emu_lfsr.sv
module trig_emu_lfsr #(
    parameter int         W    = 16,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_t;

    lfsr_t q, d;

    always_comb begin
        d    = q;
        d.sr = {q.sr[W-2:0], q.sr[15] ^ q.sr[13] ^ q.sr[12] ^ q.sr[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.sr <= W'(SEED);
        else        q    <= d;
    end

    assign value_o = q.sr;
endmodule

// File: rtl/trig_emu_seq.sv
module trig_emu_seq
    import trig_emu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [CNT_W-1:0] d0_i,
    input  logic [CNT_W-1:0] d1_i,
    input  logic [CNT_W-1:0] d2_i,
    output logic             busy_o,
    output hit_t             hit_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] d0;
        logic [CNT_W-1:0] d1;
        logic [CNT_W-1:0] d2;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (q.busy) begin
            d.cnt = q.cnt + ONE;
            if (q.cnt == q.d2) d.busy = 1'b0;
        end
        if (accept_i) begin
            d.busy = 1'b1;
            d.cnt  = ONE;
            d.d0   = d0_i;
            d.d1   = d1_i;
            d.d2   = d2_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        hit_o.first     = q.busy && (q.cnt == q.d0);
        hit_o.stb       = q.busy && (q.cnt == q.d1);
        hit_o.mid_msg   = q.busy && (q.cnt == q.d1 + ONE);
        hit_o.fin       = q.busy && (q.cnt == q.d2);
        hit_o.fin_early = q.busy && (q.cnt == q.d2 - ONE);
    end

    assign busy_o = q.busy;
endmodule

// File: rtl/trig_emu_out.sv
module trig_emu_out
    import trig_emu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hit_t              hit_i,
    input  logic              inj_i,
    input  err_kind_e         kind_i,
    input  logic              on_a_i,
    input  logic [DATA_W-1:0] num_i,
    output logic              l0_o,
    output logic              chan_a_o,
    output logic              msg_valid_o,
    output logic              msg_lvl_o,
    output logic [DATA_W-1:0] msg_data_o
);
    typedef struct packed {
        logic              l0;
        logic              cha;
        logic              mv;
        logic              ml;
        logic [DATA_W-1:0] md;
    } out_t;

    out_t q, d;
    logic drop_stb, drop_fin, flip, early, fin_hit;

    always_comb begin
        drop_stb = inj_i && (kind_i == ERR_DROP_STB);
        drop_fin = inj_i && (kind_i == ERR_DROP_FIN);
        flip     = inj_i && (kind_i == ERR_FLIP_BIT);
        early    = inj_i && (kind_i == ERR_EARLY);
        fin_hit  = early ? hit_i.fin_early : hit_i.fin;

        d     = '0;
        d.l0  = hit_i.first && !on_a_i;
        d.cha = (hit_i.first && on_a_i) || (hit_i.stb && !drop_stb);
        if (hit_i.mid_msg) begin
            d.mv = 1'b1;
            d.ml = 1'b0;
            d.md = flip ? (num_i ^ DATA_W'(1)) : num_i;
        end else if (fin_hit && !drop_fin) begin
            d.mv = 1'b1;
            d.ml = 1'b1;
            d.md = num_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign l0_o        = q.l0;
    assign chan_a_o    = q.cha;
    assign msg_valid_o = q.mv;
    assign msg_lvl_o   = q.ml;
    assign msg_data_o  = q.md;
endmodule

// File: rtl/trig_seq_emu.sv
module trig_seq_emu
    import trig_emu_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          CNT_W     = 16,
    parameter int          L0_DEF    = 48,
    parameter int          L1_DEF    = 260,
    parameter int          L2_DEF    = 3520,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              l0_on_a_i,
    input  logic [CNT_W-1:0]  l0_dly_i,
    input  logic [CNT_W-1:0]  l1_dly_i,
    input  logic [CNT_W-1:0]  l2_dly_i,
    input  logic              err_rand_en_i,
    input  logic [15:0]       err_thresh_i,
    input  logic              err_now_i,
    input  logic [1:0]        err_kind_i,
    output logic              l0_o,
    output logic              chan_a_o,
    output logic              msg_valid_o,
    output logic              msg_lvl_o,
    output logic [DATA_W-1:0] msg_data_o,
    output logic              busy_o
);
    localparam int               LFSR_W = 16;
    localparam logic [CNT_W-1:0] D0_DEF = CNT_W'(L0_DEF);
    localparam logic [CNT_W-1:0] D1_DEF = CNT_W'(L1_DEF);
    localparam logic [CNT_W-1:0] D2_DEF = CNT_W'(L2_DEF);

    typedef struct packed {
        logic              pend;
        logic              inj;
        err_kind_e         kind;
        logic              on_a;
        logic [DATA_W-1:0] ev;
        logic [DATA_W-1:0] num;
    } ctl_t;

    ctl_t q, d;

    logic [LFSR_W-1:0] lfsr_val;
    logic              accept, rand_hit;
    logic [CNT_W-1:0]  d0, d1, d2;
    hit_t              hit;

    trig_emu_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .value_o(lfsr_val)
    );

    assign d0 = (l0_dly_i == '0) ? D0_DEF : l0_dly_i;
    assign d1 = (l1_dly_i == '0) ? D1_DEF : l1_dly_i;
    assign d2 = (l2_dly_i == '0) ? D2_DEF : l2_dly_i;

    always_comb begin
        accept   = start_i && !busy_o;
        rand_hit = err_rand_en_i && (lfsr_val <= err_thresh_i);
        d = q;
        if (accept) begin
            d.inj  = q.pend || err_now_i || rand_hit;
            d.kind = err_kind_e'(err_kind_i);
            d.on_a = l0_on_a_i;
            d.num  = q.ev;
            d.ev   = q.ev + DATA_W'(1);
            d.pend = 1'b0;
        end else if (err_now_i) begin
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    trig_emu_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept_i(accept),
        .d0_i(d0), .d1_i(d1), .d2_i(d2),
        .busy_o(busy_o), .hit_o(hit)
    );

    trig_emu_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .hit_i(hit),
        .inj_i(q.inj), .kind_i(q.kind), .on_a_i(q.on_a), .num_i(q.num),
        .l0_o(l0_o), .chan_a_o(chan_a_o), .msg_valid_o(msg_valid_o),
        .msg_lvl_o(msg_lvl_o), .msg_data_o(msg_data_o)
    );
endmodule

// File: rtl/trig_emu_chk.sv
module trig_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic l0_o,
    input logic chan_a_o,
    input logic msg_valid_o,
    input logic msg_lvl_o,
    input logic busy_o
);
    // R2: a sequence only begins from a start request
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R3: fast line is a single-cycle pulse inside a sequence
    assert_l0_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        l0_o |=> !l0_o);
    assert_l0_in_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        l0_o |-> busy_o);

    // R4: strobe channel pulses last one cycle
    assert_stb_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_a_o |=> !chan_a_o);

    // R5: second-level message lies inside the busy window
    assert_mid_msg_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_lvl_o) |-> busy_o);

    // R6: final message follows a busy cycle
    assert_fin_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && msg_lvl_o) |-> $past(busy_o));
endmodule

bind trig_seq_emu trig_emu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .l0_o(l0_o),
    .chan_a_o(chan_a_o), .msg_valid_o(msg_valid_o), .msg_lvl_o(msg_lvl_o),
    .busy_o(busy_o)
);

// File: tb/trig_seq_emu_tb.sv
module trig_seq_emu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        l0_on_a_i = 1'b0;
    logic [15:0] l0_dly_i = 16'd3;
    logic [15:0] l1_dly_i = 16'd8;
    logic [15:0] l2_dly_i = 16'd20;
    logic        err_rand_en_i = 1'b0;
    logic [15:0] err_thresh_i = 16'd0;
    logic        err_now_i = 1'b0;
    logic [1:0]  err_kind_i = 2'd0;
    logic        l0_o, chan_a_o, msg_valid_o, msg_lvl_o, busy_o;
    logic [15:0] msg_data_o;

    trig_seq_emu dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .l0_on_a_i(l0_on_a_i),
        .l0_dly_i(l0_dly_i), .l1_dly_i(l1_dly_i), .l2_dly_i(l2_dly_i),
        .err_rand_en_i(err_rand_en_i), .err_thresh_i(err_thresh_i),
        .err_now_i(err_now_i), .err_kind_i(err_kind_i),
        .l0_o(l0_o), .chan_a_o(chan_a_o), .msg_valid_o(msg_valid_o),
        .msg_lvl_o(msg_lvl_o), .msg_data_o(msg_data_o), .busy_o(busy_o)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    string tag = "R1";

    // behavioural reference: expected outputs keyed by edge number
    int       cyc = 0;
    bit       m_busy = 0, m_pend = 0;
    int       m_end = 0;
    int       m_ev = 0;
    bit       e_l0[int];
    bit       e_a[int];
    bit       e_mv[int];
    bit       e_ml[int];
    int       e_md[int];

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; m_busy = 0; m_pend = 0; m_ev = 0;
        end else begin
            bit bp, inj;
            int k0, k1, k2, kd, t;
            cyc = cyc + 1;
            bp = m_busy;
            if (m_busy && cyc == m_end) m_busy = 0;
            if (start_i && !bp) begin
                k0 = (l0_dly_i == 0) ? 48 : int'(l0_dly_i);
                k1 = (l1_dly_i == 0) ? 260 : int'(l1_dly_i);
                k2 = (l2_dly_i == 0) ? 3520 : int'(l2_dly_i);
                inj = m_pend || err_now_i || (err_rand_en_i && err_thresh_i == 16'hFFFF);
                kd = int'(err_kind_i);
                if (l0_on_a_i) e_a[cyc + k0] = 1; else e_l0[cyc + k0] = 1;
                if (!(inj && kd == 0)) e_a[cyc + k1] = 1;
                e_mv[cyc + k1 + 1] = 1;
                e_ml[cyc + k1 + 1] = 0;
                e_md[cyc + k1 + 1] = (inj && kd == 2) ? ((m_ev ^ 1) & 16'hFFFF) : m_ev;
                if (!(inj && kd == 1)) begin
                    t = (inj && kd == 3) ? cyc + k2 - 1 : cyc + k2;
                    e_mv[t] = 1; e_ml[t] = 1; e_md[t] = m_ev;
                end
                m_busy = 1; m_end = cyc + k2;
                m_ev = (m_ev + 1) & 16'hFFFF;
                m_pend = 0;
            end else if (err_now_i) begin
                m_pend = 1;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 l0_o in reset", int'(l0_o), 0);
            chk("R1 chan_a_o in reset", int'(chan_a_o), 0);
            chk("R1 msg_valid_o in reset", int'(msg_valid_o), 0);
            chk("R1 busy_o in reset", int'(busy_o), 0);
        end else begin
            bit xv;
            chk("R3 l0_o", int'(l0_o), e_l0.exists(cyc) ? 1 : 0);
            chk("R4 chan_a_o", int'(chan_a_o), e_a.exists(cyc) ? 1 : 0);
            xv = e_mv.exists(cyc);
            chk("R5/R6 msg_valid_o", int'(msg_valid_o), xv ? 1 : 0);
            if (xv && msg_valid_o) begin
                chk("R5/R6 msg_lvl_o", int'(msg_lvl_o), int'(e_ml[cyc]));
                chk("R5/R6 msg_data_o", int'(msg_data_o), e_md[cyc]);
            end
            chk("R2 busy_o", int'(busy_o), int'(m_busy));
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_seq(input int a, input int b, input int c, input bit on_a,
                           input bit now);
        @(negedge clk);
        l0_dly_i = 16'(a); l1_dly_i = 16'(b); l2_dly_i = 16'(c);
        l0_on_a_i = on_a; err_now_i = now; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; err_now_i = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        chk("R1 busy_o after reset", int'(busy_o), 0);
        chk("R1 l0_o after reset", int'(l0_o), 0);

        tag = "R2"; run_seq(3, 8, 20, 0, 0);
        tag = "R3"; run_seq(1, 5, 9, 1, 0);
        tag = "R5"; run_seq(7, 30, 60, 0, 0);

        // R7: a start inside a running sequence is ignored
        tag = "R7";
        @(negedge clk);
        l0_dly_i = 16'd3; l1_dly_i = 16'd8; l2_dly_i = 16'd20; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (5) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_idle();

        // R2: start held high, next sequence taken right after busy drops
        tag = "R2";
        begin
            int base;
            base = m_ev;
            @(negedge clk); start_i = 1'b1;
            while (m_ev != ((base + 2) & 16'hFFFF)) @(negedge clk);
            start_i = 1'b0;
            wait_idle();
        end

        // R10: each error kind on demand, each followed by a clean sequence
        for (int k = 0; k < 4; k++) begin
            tag = "R10";
            err_kind_i = 2'(k);
            run_seq(3, 8, 20, 0, 1);
            tag = "R8";
            run_seq(3, 8, 20, 0, 0);
        end

        // R8: request ahead of the start, held pending
        tag = "R8";
        err_kind_i = 2'd2;
        @(negedge clk); err_now_i = 1'b1;
        @(negedge clk); err_now_i = 1'b0;
        repeat (4) @(negedge clk);
        run_seq(2, 6, 15, 0, 0);
        run_seq(2, 6, 15, 0, 0);

        // R9: random marking at the threshold extremes
        tag = "R9";
        err_rand_en_i = 1'b1; err_kind_i = 2'd1; err_thresh_i = 16'hFFFF;
        run_seq(3, 8, 20, 0, 0);
        run_seq(4, 9, 25, 0, 0);
        err_thresh_i = 16'd0; err_kind_i = 2'd3;
        run_seq(3, 8, 20, 0, 0);
        run_seq(3, 8, 20, 1, 0);
        err_rand_en_i = 1'b0;

        // R11: zero latency inputs select defaults
        tag = "R11";
        run_seq(0, 0, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog %s act=hung exp=done", tag);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule